// File: doc/BRIEF.md
# UART Control/Data Register Interface with Level Interrupts

This block sits between a simple processor bus and the FIFOs of a serial transceiver. It holds the transceiver's configuration in a control word and exposes it as separate fields: enable, simulation mode, flow-control enable, a 3-bit prescaler select and a 10-bit baud divisor. On reads, the same word reports the live FIFO status, a sticky receive-overflow flag and a transmit-busy indication. A second word moves bytes. A write to it queues a byte into the transmit FIFO. A read of it returns the byte at the head of the receive FIFO, removes that byte, and also reports the log2 depth of both FIFOs.

Two interrupt lines are produced, one for receive and one for transmit. Each line is the OR of the FIFO-level conditions that software has enabled. The line stays high for as long as any enabled condition remains true. The serial engines and the clearing of pending interrupts on the CPU side are outside this block.

All outputs are registered. A bus access at one clock edge shows its effect at the outputs after that edge. The reset is synchronous and active high.

Top module: `uart_regfile`

## Requirements
- R1: After reset, every configuration output, both interrupt lines, `tx_push`, `tx_data`, `rx_pop` and `bus_rdata` are zero.
- R2: A write with `bus_addr`=0 stores the following fields, each visible on its `cfg_*` output after the edge:
  - bit 0: enable
  - bit 1: simulation mode
  - bit 2: flow control
  - bits 5:3: prescaler
  - bits 15:6: divisor
  - bits 24:22: RX interrupt enables
  - bits 26:25: TX interrupt enables
  Write data in bits 21:16 and 31:27 is discarded.
- R3: A read with `bus_addr`=0 returns the stored fields at the positions of R2, together with these read-only bits:
  - bit 16: RX not empty
  - bit 17: RX at least half full
  - bit 18: RX full
  - bit 19: TX empty
  - bit 20: TX below half full
  - bit 21: TX full
  - bits 29:27: zero
  - bit 31: `tx_busy` OR not TX empty
- R4: A read with `bus_addr`=1 returns `rx_data` in bits 7:0, the RX log2 depth in bits 11:8, the TX log2 depth in bits 15:12, and zero in bits 31:16.
- R5: A write with `bus_addr`=1 while `tx_full` is low gives a one-cycle `tx_push` with `tx_data` equal to write-data bits 7:0. While `tx_full` is high, no push occurs.
- R6: A read with `bus_addr`=1 while `rx_nempty` is high gives a one-cycle `rx_pop`. While the RX FIFO is empty, no pop occurs.
- R7: The overflow flag (control bit 30) is set at an edge where `rx_overrun` is high and the stored enable is 1. It is cleared at every edge where the stored enable is 0.
- R8: `irq_rx` equals, one cycle later, the OR of the enabled RX conditions: enable bit 22 with not-empty, bit 23 with half-full, bit 24 with full.
- R9: `irq_tx` equals, one cycle later, the OR of the enabled TX conditions: enable bit 25 with TX empty, and enable bit 26 with TX below half full (`tx_half` low).
- R10: `bus_rdata` is zero in every cycle that does not follow a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_addr | input | 1 | Word select: 0 control, 1 data |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| rx_nempty | input | 1 | RX FIFO holds at least one byte |
| rx_half | input | 1 | RX FIFO at least half full |
| rx_full | input | 1 | RX FIFO full |
| rx_data | input | 8 | Byte at RX FIFO head |
| rx_overrun | input | 1 | Receiver dropped a byte this cycle |
| tx_empty | input | 1 | TX FIFO empty |
| tx_half | input | 1 | TX FIFO at least half full |
| tx_full | input | 1 | TX FIFO full |
| tx_busy | input | 1 | Transmitter shifting a frame |
| cfg_enable | output | 1 | Block enable |
| cfg_sim_mode | output | 1 | Simulation mode select |
| cfg_flow_ctrl | output | 1 | Hardware flow control enable |
| cfg_prescale | output | 3 | Clock prescaler select |
| cfg_divisor | output | 10 | Baud divisor |
| tx_push | output | 1 | One-cycle TX FIFO write strobe |
| tx_data | output | 8 | Byte for TX FIFO |
| rx_pop | output | 1 | One-cycle RX FIFO read strobe |
| irq_rx | output | 1 | Receive interrupt |
| irq_tx | output | 1 | Transmit interrupt |

## Verification
The bench overrides the depth parameters to an 8-entry RX FIFO (log2 3) and a 4-entry TX FIFO (log2 2). The two depth fields in the data word therefore hold different non-zero values, so a swapped or mis-shifted field shows up on readback. With the small depths, random fill levels reach empty, half full and full often. This drives every interrupt condition, both push/pop guards and the busy term in many combinations. Random writes to the control word toggle the enable bit, so the overflow flag is set and cleared many times.

// File: rtl/uart_regfile_pkg.sv
package uart_regfile_pkg;
  localparam int REG_W   = 32;
  localparam int BYTE_W  = 8;
  localparam int PRSC_W  = 3;
  localparam int DIV_W   = 10;
  localparam int LOG_W   = 4;
  localparam int RXIE_W  = 3;
  localparam int TXIE_W  = 2;

  localparam int B_EN    = 0;
  localparam int B_SIM   = 1;
  localparam int B_FLOW  = 2;
  localparam int B_PRSC  = 3;
  localparam int B_DIV   = 6;
  localparam int B_STAT  = 16;
  localparam int B_RXIE  = 22;
  localparam int B_TXIE  = 25;
  localparam int B_OVF   = 30;
  localparam int B_BUSY  = 31;
  localparam int B_RXLOG = 8;
  localparam int B_TXLOG = 12;

  typedef struct packed {
    logic [TXIE_W-1:0] tx_ie;
    logic [RXIE_W-1:0] rx_ie;
    logic [DIV_W-1:0]  divisor;
    logic [PRSC_W-1:0] prescale;
    logic              flow;
    logic              sim;
    logic              en;
  } cfg_t;

  typedef struct packed {
    logic tx_full;
    logic tx_below_half;
    logic tx_empty;
    logic rx_full;
    logic rx_half;
    logic rx_nempty;
  } stat_t;
endpackage

// File: rtl/uart_cfg_reg.sv
module uart_cfg_reg
  import uart_regfile_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_ctrl,
  input  logic [REG_W-1:0] wdata,
  input  logic             overrun,
  output cfg_t             cfg,
  output logic             ovf
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= '0;
    end else if (wr_ctrl) begin
      cfg.en       <= wdata[B_EN];
      cfg.sim      <= wdata[B_SIM];
      cfg.flow     <= wdata[B_FLOW];
      cfg.prescale <= wdata[B_PRSC +: PRSC_W];
      cfg.divisor  <= wdata[B_DIV +: DIV_W];
      cfg.rx_ie    <= wdata[B_RXIE +: RXIE_W];
      cfg.tx_ie    <= wdata[B_TXIE +: TXIE_W];
    end
  end

  // sticky overflow, held clear while the block is disabled
  always_ff @(posedge clk) begin
    if (rst || !cfg.en) ovf <= 1'b0;
    else if (overrun)   ovf <= 1'b1;
  end
endmodule

// File: rtl/uart_level_irq.sv
module uart_level_irq #(
  parameter int N_COND = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_COND-1:0] enable,
  input  logic [N_COND-1:0] cond,
  output logic              irq
);
  logic [N_COND-1:0] hit;

  for (genvar i = 0; i < N_COND; i++) begin : g_term
    assign hit[i] = enable[i] & cond[i];
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |hit;
  end
endmodule

// File: rtl/uart_bus_port.sv
module uart_bus_port
  import uart_regfile_pkg::*;
#(
  parameter int RX_LOG2 = 4,
  parameter int TX_LOG2 = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic              bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  input  cfg_t              cfg,
  input  logic              ovf,
  input  stat_t             stat,
  input  logic              tx_busy,
  input  logic [BYTE_W-1:0] rx_data,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              tx_push,
  output logic [BYTE_W-1:0] tx_data,
  output logic              rx_pop
);
  localparam logic [LOG_W-1:0] RX_LOG_F = LOG_W'(RX_LOG2);
  localparam logic [LOG_W-1:0] TX_LOG_F = LOG_W'(TX_LOG2);

  logic [REG_W-1:0] ctrl_word;
  logic [REG_W-1:0] data_word;

  always_comb begin
    ctrl_word = '0;
    ctrl_word[B_EN]                  = cfg.en;
    ctrl_word[B_SIM]                 = cfg.sim;
    ctrl_word[B_FLOW]                = cfg.flow;
    ctrl_word[B_PRSC +: PRSC_W]      = cfg.prescale;
    ctrl_word[B_DIV +: DIV_W]        = cfg.divisor;
    ctrl_word[B_STAT +: $bits(stat_t)] = stat;
    ctrl_word[B_RXIE +: RXIE_W]      = cfg.rx_ie;
    ctrl_word[B_TXIE +: TXIE_W]      = cfg.tx_ie;
    ctrl_word[B_OVF]                 = ovf;
    ctrl_word[B_BUSY]                = tx_busy | ~stat.tx_empty;
  end

  always_comb begin
    data_word = '0;
    data_word[0 +: BYTE_W]      = rx_data;
    data_word[B_RXLOG +: LOG_W] = RX_LOG_F;
    data_word[B_TXLOG +: LOG_W] = TX_LOG_F;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      tx_push   <= 1'b0;
      tx_data   <= '0;
      rx_pop    <= 1'b0;
    end else begin
      bus_rdata <= bus_re ? (bus_addr ? data_word : ctrl_word) : '0;
      rx_pop    <= bus_re & bus_addr & stat.rx_nempty;
      tx_push   <= bus_we & bus_addr & ~stat.tx_full;
      if (bus_we && bus_addr && !stat.tx_full) tx_data <= bus_wdata[BYTE_W-1:0];
    end
  end
endmodule

// File: rtl/uart_regfile.sv
module uart_regfile
  import uart_regfile_pkg::*;
#(
  parameter int RX_LOG2 = 4,
  parameter int TX_LOG2 = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_we,
  input  logic        bus_re,
  input  logic        bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        rx_nempty,
  input  logic        rx_half,
  input  logic        rx_full,
  input  logic [7:0]  rx_data,
  input  logic        rx_overrun,
  input  logic        tx_empty,
  input  logic        tx_half,
  input  logic        tx_full,
  input  logic        tx_busy,
  output logic        cfg_enable,
  output logic        cfg_sim_mode,
  output logic        cfg_flow_ctrl,
  output logic [2:0]  cfg_prescale,
  output logic [9:0]  cfg_divisor,
  output logic        tx_push,
  output logic [7:0]  tx_data,
  output logic        rx_pop,
  output logic        irq_rx,
  output logic        irq_tx
);
  cfg_t  cfg_q;
  logic  sts_ovf;
  stat_t stat;

  assign stat.rx_nempty     = rx_nempty;
  assign stat.rx_half       = rx_half;
  assign stat.rx_full       = rx_full;
  assign stat.tx_empty      = tx_empty;
  assign stat.tx_below_half = ~tx_half;
  assign stat.tx_full       = tx_full;

  uart_cfg_reg u_cfg (
    .clk     (clk),
    .rst     (rst),
    .wr_ctrl (bus_we & ~bus_addr),
    .wdata   (bus_wdata),
    .overrun (rx_overrun),
    .cfg     (cfg_q),
    .ovf     (sts_ovf)
  );

  uart_bus_port #(.RX_LOG2(RX_LOG2), .TX_LOG2(TX_LOG2)) u_port (
    .clk       (clk),
    .rst       (rst),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .cfg       (cfg_q),
    .ovf       (sts_ovf),
    .stat      (stat),
    .tx_busy   (tx_busy),
    .rx_data   (rx_data),
    .bus_rdata (bus_rdata),
    .tx_push   (tx_push),
    .tx_data   (tx_data),
    .rx_pop    (rx_pop)
  );

  uart_level_irq #(.N_COND(RXIE_W)) u_irq_rx (
    .clk    (clk),
    .rst    (rst),
    .enable (cfg_q.rx_ie),
    .cond   ({stat.rx_full, stat.rx_half, stat.rx_nempty}),
    .irq    (irq_rx)
  );

  uart_level_irq #(.N_COND(TXIE_W)) u_irq_tx (
    .clk    (clk),
    .rst    (rst),
    .enable (cfg_q.tx_ie),
    .cond   ({stat.tx_below_half, stat.tx_empty}),
    .irq    (irq_tx)
  );

  assign cfg_enable    = cfg_q.en;
  assign cfg_sim_mode  = cfg_q.sim;
  assign cfg_flow_ctrl = cfg_q.flow;
  assign cfg_prescale  = cfg_q.prescale;
  assign cfg_divisor   = cfg_q.divisor;
endmodule

// File: rtl/uart_regfile_chk.sv
module uart_regfile_chk (
  input logic        clk,
  input logic        rst,
  input logic        bus_we,
  input logic        bus_re,
  input logic        bus_addr,
  input logic [31:0] bus_rdata,
  input logic        rx_nempty,
  input logic        rx_half,
  input logic        rx_full,
  input logic        tx_empty,
  input logic        tx_half,
  input logic        tx_full,
  input logic        tx_push,
  input logic        rx_pop,
  input logic        cfg_enable,
  input logic        ovf_q,
  input logic [2:0]  rx_ie,
  input logic [1:0]  tx_ie,
  input logic        irq_rx,
  input logic        irq_tx
);
  AST_PUSH_CAUSE: assert property (@(posedge clk) disable iff (rst)
    tx_push |-> !$past(rst) && $past(bus_we && bus_addr && !tx_full)); // R5
  AST_PUSH_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(bus_we && bus_addr && !tx_full)) |-> tx_push); // R5
  AST_POP_CAUSE: assert property (@(posedge clk) disable iff (rst)
    rx_pop |-> !$past(rst) && $past(bus_re && bus_addr && rx_nempty)); // R6
  AST_OVF_CLEARED: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(cfg_enable)) |-> !ovf_q); // R7
  AST_IRQ_RX_LEVEL: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> irq_rx == $past(|(rx_ie & {rx_full, rx_half, rx_nempty}))); // R8
  AST_IRQ_TX_LEVEL: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> irq_tx == $past(|(tx_ie & {~tx_half, tx_empty}))); // R9
  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(bus_re)) |-> bus_rdata == 32'd0); // R10
  AST_CTRL_RSVD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(bus_re && !bus_addr)) |-> bus_rdata[29:27] == 3'd0); // R3
endmodule

bind uart_regfile uart_regfile_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_we     (bus_we),
  .bus_re     (bus_re),
  .bus_addr   (bus_addr),
  .bus_rdata  (bus_rdata),
  .rx_nempty  (rx_nempty),
  .rx_half    (rx_half),
  .rx_full    (rx_full),
  .tx_empty   (tx_empty),
  .tx_half    (tx_half),
  .tx_full    (tx_full),
  .tx_push    (tx_push),
  .rx_pop     (rx_pop),
  .cfg_enable (cfg_enable),
  .ovf_q      (sts_ovf),
  .rx_ie      (cfg_q.rx_ie),
  .tx_ie      (cfg_q.tx_ie),
  .irq_rx     (irq_rx),
  .irq_tx     (irq_tx)
);

// File: tb/tb_uart_regfile.sv
`timescale 1ns/1ps
module tb_uart_regfile;
  localparam int RXL = 3;
  localparam int TXL = 2;
  localparam int RXD = 1 << RXL;
  localparam int TXD = 1 << TXL;
  localparam logic [31:0] RW_MASK = 32'h07C0_FFFF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_we = 0, bus_re = 0, bus_addr = 0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic rx_nempty = 0, rx_half = 0, rx_full = 0, rx_overrun = 0;
  logic [7:0] rx_data = '0;
  logic tx_empty = 1, tx_half = 0, tx_full = 0, tx_busy = 0;
  logic cfg_enable, cfg_sim_mode, cfg_flow_ctrl;
  logic [2:0] cfg_prescale;
  logic [9:0] cfg_divisor;
  logic tx_push, rx_pop, irq_rx, irq_tx;
  logic [7:0] tx_data;

  always #4 clk = ~clk;

  uart_regfile #(.RX_LOG2(RXL), .TX_LOG2(TXL)) dut (.*);

  int n_chk = 0, n_fail = 0;

  logic [31:0] m_ctrl = '0, m_rdata = '0;
  logic m_ovf = 0, m_irx = 0, m_itx = 0, m_push = 0, m_pop = 0;
  logic [7:0] m_txd = '0;
  int m_kind = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ctrl_word();
    logic [31:0] w;
    w = m_ctrl & RW_MASK;
    w[16] = rx_nempty; w[17] = rx_half; w[18] = rx_full;
    w[19] = tx_empty;  w[20] = ~tx_half; w[21] = tx_full;
    w[30] = m_ovf;
    w[31] = tx_busy | ~tx_empty;
    return w;
  endfunction

  function automatic logic [31:0] data_word();
    return {16'd0, 4'(TXL), 4'(RXL), rx_data};
  endfunction

  task automatic set_levels(input int rl, input int tl);
    rx_nempty = (rl > 0); rx_half = (rl >= RXD/2); rx_full = (rl == RXD);
    tx_empty  = (tl == 0); tx_half = (tl >= TXD/2); tx_full = (tl == TXD);
  endtask

  task automatic step();
    logic [31:0] n_ctrl, n_rd;
    logic n_ovf, n_irx, n_itx, n_push, n_pop;
    logic [7:0] n_txd;
    int n_kind;
    if (rst) begin
      n_ctrl = '0; n_rd = '0; n_ovf = 0; n_irx = 0; n_itx = 0;
      n_push = 0; n_pop = 0; n_txd = '0; n_kind = 0;
    end else begin
      n_ctrl = (bus_we && !bus_addr) ? (bus_wdata & RW_MASK) : m_ctrl;
      n_kind = bus_re ? (bus_addr ? 2 : 1) : 0;
      n_rd   = bus_re ? (bus_addr ? data_word() : ctrl_word()) : 32'd0;
      n_ovf  = !m_ctrl[0] ? 1'b0 : (rx_overrun ? 1'b1 : m_ovf);
      n_irx  = |(m_ctrl[24:22] & {rx_full, rx_half, rx_nempty});
      n_itx  = |(m_ctrl[26:25] & {~tx_half, tx_empty});
      n_push = bus_we && bus_addr && !tx_full;
      n_pop  = bus_re && bus_addr && rx_nempty;
      n_txd  = n_push ? bus_wdata[7:0] : m_txd;
    end
    @(posedge clk);
    @(negedge clk);
    m_ctrl = n_ctrl; m_rdata = n_rd; m_ovf = n_ovf; m_irx = n_irx; m_itx = n_itx;
    m_push = n_push; m_pop = n_pop; m_txd = n_txd; m_kind = n_kind;
    if (!rst) begin
      chk("R2 cfg fields", {13'd0, cfg_divisor, cfg_prescale, cfg_flow_ctrl, cfg_sim_mode, cfg_enable},
          {13'd0, m_ctrl[15:0]});
      if (m_kind == 1) begin
        chk("R3 ctrl read", bus_rdata & ~32'h4000_0000, m_rdata & ~32'h4000_0000);
        chk("R7 overflow bit", 32'(bus_rdata[30]), 32'(m_rdata[30]));
      end else if (m_kind == 2) chk("R4 data read", bus_rdata, m_rdata);
      else chk("R10 idle rdata", bus_rdata, 32'd0);
      chk("R5 tx_push", 32'(tx_push), 32'(m_push));
      if (m_push) chk("R5 tx_data", 32'(tx_data), 32'(m_txd));
      chk("R6 rx_pop", 32'(rx_pop), 32'(m_pop));
      chk("R8 irq_rx", 32'(irq_rx), 32'(m_irx));
      chk("R9 irq_tx", 32'(irq_tx), 32'(m_itx));
    end
  endtask

  task automatic idle();
    bus_we = 0; bus_re = 0; rx_overrun = 0;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) step();
    rst = 0;
    @(negedge clk);
    // R1: reset state
    chk("R1 rdata", bus_rdata, 32'd0);
    chk("R1 cfg", {19'd0, cfg_divisor, cfg_prescale}, 32'd0);
    chk("R1 flags", {26'd0, cfg_enable, cfg_sim_mode, cfg_flow_ctrl, tx_push, rx_pop, irq_rx | irq_tx},
        32'd0);
    chk("R1 tx_data", 32'(tx_data), 32'd0);

    // R2/R3: all-ones write, reserved and status bits discarded
    set_levels(0, 0);
    bus_we = 1; bus_addr = 0; bus_wdata = 32'hFFFF_FFFF; step();
    idle(); bus_re = 1; step();
    idle(); step();
    // R6: read DATA while RX empty gives no pop
    bus_re = 1; bus_addr = 1; rx_data = 8'hA5; step();
    idle(); step();
    // R5: write DATA while TX full gives no push
    set_levels(RXD, TXD);
    bus_we = 1; bus_addr = 1; bus_wdata = 32'h0000_003C; step();
    idle(); step();
    // R7: overflow set while enabled, then cleared on disable
    rx_overrun = 1; step();
    idle(); bus_re = 1; bus_addr = 0; step();
    idle(); bus_we = 1; bus_addr = 0; bus_wdata = 32'h0; step();
    idle(); step();
    bus_re = 1; bus_addr = 0; step();
    idle(); rx_overrun = 1; step();
    idle(); bus_re = 1; bus_addr = 0; step();
    // R8/R9: each condition alone
    idle(); bus_we = 1; bus_wdata = 32'h07C0_0001; step();
    for (int k = 0; k <= RXD; k++) begin
      idle(); set_levels(k, k % (TXD + 1)); step();
    end

    for (int i = 0; i < 4000; i++) begin
      bus_we = ($urandom % 3) == 0;
      bus_re = ($urandom % 3) == 0;
      bus_addr = $urandom % 2;
      bus_wdata = $urandom;
      if (!bus_addr && ($urandom % 4 != 0)) bus_wdata[0] = 1'b1;
      rx_overrun = ($urandom % 6) == 0;
      tx_busy = $urandom % 2;
      rx_data = 8'($urandom);
      set_levels($urandom_range(0, RXD), $urandom_range(0, TXD));
      step();
    end
    idle(); step();
    summary();
  end
endmodule